// File: doc/BRIEF.md
# Flash Bank Mode Controller

This block keeps track of the operating mode of a set of flash banks: one program bank and a group of data banks. Each bank is either in read mode, where array reads proceed and command sequences may be entered, or in command mode, where a program or erase operation runs on the array. The block watches a simple bus-write port. Writes whose address selects a bank feed that bank's command-sequence decoder. Writes that select the register space are acknowledged in every state.

A command is a fixed-length sequence of bus writes. Every cycle before the last carries an unlock key. The last cycle carries an operation code. A program (write-page) or erase code that passes the protection and concurrency checks moves the bank into command mode and pulses a start strobe toward the array model. The bank then waits for the array's done strobe and returns to read mode. A reset-to-read code, a wrong key, a wrong order, a locked or read-protected target, or a refused concurrent request all leave the bank in read mode, or leave a running operation undisturbed, and report through one-cycle status pulses.

While page mode is enabled, writes to the upper quarter of a bank's offset space load the page assembly buffer. These writes do not disturb a command sequence that is in progress.

Top module: `fbmc_top`

## Requirements
- R1: After reset every bank is in read mode (cmd_mode_o all zero) and ready_o is low. For RAMP_CYCLES clock edges after reset release, bank-space writes have no effect: no start, no status pulse, no mode change. Then ready_o rises.
- R2: A command is SEQ_LEN writes to one bank. Stages at even index expect offset 0x55 with data 0xAA. Stages at odd index expect offset 0xAA with data 0x55. The bank stays in read mode while these key writes are accepted.
- R3: A last-stage write at offset 0x55 with data 0xA0 (program) or 0x80 (erase) that is permitted sets cmd_mode_o for that bank in the cycle after the write. In that same cycle arr_start_o pulses for one cycle, and arr_erase_o shows 1 for erase and 0 for program.
- R4: A busy bank returns to read mode in the cycle after arr_done_i is sampled high for that bank.
- R5: A last-stage write of data 0xF0 (reset-to-read) keeps a read-mode bank in read mode without any status pulse. It has no effect on a bank whose operation is running.
- R6: A write to a bank's command space that does not match the expected stage (wrong offset, wrong data or wrong order) pulses seq_err_o for that bank in the next cycle. It returns that bank's sequence to the first stage, and the next correct full sequence is accepted.
- R7: Program or erase on a bank with lock_i set, or program on a bank with rdprot_i set, pulses prot_err_o in the next cycle and starts nothing. Erase on a read-protected but unlocked bank is allowed.
- R8: Bank 0 is the program bank. A program or erase request is refused with a seq_err_o pulse whenever any other bank is busy, except in one case: two data banks may be busy together when one programs and the other erases. A refused request leaves every busy bank busy.
- R9: A write with bank select 3 (the register space, address bits [9:8]) is acknowledged by reg_ack_o in the next cycle in every state, including the ramp interval and command mode.
- R10: With page_mode_i high, a write to offsets 0xC0 to 0xFF of a bank in read mode pulses pbuf_ack_o in the next cycle and leaves that bank's sequence stage unchanged. The same write to a busy bank gives seq_err_o, and to a read-protected bank gives prot_err_o. With page_mode_i low, such a write is a sequence fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | 10 | Bits [9:8] select the bank (3 = register space); bits [7:0] are the offset |
| wr_data_i | input | 8 | Bus write data |
| page_mode_i | input | 1 | Page mode enable |
| lock_i | input | 3 | Per-bank sector lock (password not satisfied) |
| rdprot_i | input | 3 | Per-bank read protection |
| arr_done_i | input | 3 | Per-bank operation-complete strobe from the array |
| ready_o | output | 1 | Ramp interval over; bank commands accepted |
| cmd_mode_o | output | 3 | Per bank: 1 = command mode (operation running), 0 = read mode |
| arr_start_o | output | 3 | Per-bank one-cycle start strobe to the array |
| arr_erase_o | output | 3 | Per-bank operation kind while busy: 1 erase, 0 program |
| seq_err_o | output | 3 | Per-bank pulse: sequence fault or refused request |
| prot_err_o | output | 3 | Per-bank pulse: lock or read-protection fault |
| pbuf_ack_o | output | 1 | Page-buffer write accepted |
| reg_ack_o | output | 1 | Register-space write acknowledged |

## Verification
The hardest situation to reach is a concurrency refusal, because it needs another bank already held in command mode with a particular operation kind while a full, valid sequence is entered on a second bank. The stimulus reaches it by holding the array done strobes back on purpose. Several banks are left busy with chosen operations. Complete sequences are then issued to the program bank and to the other data bank with both the same and the opposite operation. Random phases do the same at scale, withholding done strobes and corrupting single sequence writes. This mixes fault paths with running operations.

// File: rtl/fbmc_pkg.sv
package fbmc_pkg;

    typedef enum logic [1:0] {
        KIND_STEP,
        KIND_LAST,
        KIND_PAGE,
        KIND_FAULT
    } seq_kind_e;

    typedef enum logic [1:0] {
        OPC_PROG,
        OPC_ERASE,
        OPC_RTR,
        OPC_NONE
    } opc_e;

    localparam logic [7:0] KEY_OFF_EVEN  = 8'h55;
    localparam logic [7:0] KEY_DAT_EVEN  = 8'hAA;
    localparam logic [7:0] KEY_OFF_ODD   = 8'hAA;
    localparam logic [7:0] KEY_DAT_ODD   = 8'h55;
    localparam logic [7:0] LAST_OFF      = 8'h55;
    localparam logic [7:0] CODE_PROG     = 8'hA0;
    localparam logic [7:0] CODE_ERASE    = 8'h80;
    localparam logic [7:0] CODE_RTR      = 8'hF0;

endpackage

// File: rtl/fbmc_seq_dec.sv
module fbmc_seq_dec
    import fbmc_pkg::*;
#(
    parameter int OFF_W   = 8,
    parameter int DATA_W  = 8,
    parameter int SEQ_LEN = 3,
    parameter int STG_W   = $clog2(SEQ_LEN)
) (
    input  logic [STG_W-1:0]  stage_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              page_mode_i,
    output seq_kind_e         kind_o,
    output opc_e              opc_o
);

    localparam logic [STG_W-1:0] LAST_STAGE = STG_W'(SEQ_LEN - 1);

    logic page_region;
    logic even_match;
    logic odd_match;

    assign page_region = (off_i[OFF_W-1 -: 2] == 2'b11);
    assign even_match  = (off_i == OFF_W'(KEY_OFF_EVEN)) && (data_i == DATA_W'(KEY_DAT_EVEN));
    assign odd_match   = (off_i == OFF_W'(KEY_OFF_ODD))  && (data_i == DATA_W'(KEY_DAT_ODD));

    always_comb begin
        kind_o = KIND_FAULT;
        opc_o  = OPC_NONE;
        if (page_mode_i && page_region) begin
            kind_o = KIND_PAGE;
        end else if (stage_i == LAST_STAGE) begin
            if (off_i == OFF_W'(LAST_OFF)) begin
                if (data_i == DATA_W'(CODE_PROG)) begin
                    kind_o = KIND_LAST;
                    opc_o  = OPC_PROG;
                end else if (data_i == DATA_W'(CODE_ERASE)) begin
                    kind_o = KIND_LAST;
                    opc_o  = OPC_ERASE;
                end else if (data_i == DATA_W'(CODE_RTR)) begin
                    kind_o = KIND_LAST;
                    opc_o  = OPC_RTR;
                end
            end
        end else if (!stage_i[0]) begin
            if (even_match) kind_o = KIND_STEP;
        end else begin
            if (odd_match) kind_o = KIND_STEP;
        end
    end

endmodule

// File: rtl/fbmc_arb.sv
module fbmc_arb #(
    parameter int NUM_BANKS = 3,
    parameter int PROG_BANK = 0
) (
    input  logic [NUM_BANKS-1:0] busy_i,
    input  logic [NUM_BANKS-1:0] erase_i,
    input  logic [NUM_BANKS-1:0] req_erase_i,
    output logic [NUM_BANKS-1:0] grant_o
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_req
        always_comb begin
            grant_o[b] = 1'b1;
            for (int c = 0; c < NUM_BANKS; c++) begin
                if (c != b && busy_i[c]) begin
                    if (b == PROG_BANK || c == PROG_BANK) begin
                        grant_o[b] = 1'b0;
                    end else if (erase_i[c] == req_erase_i[b]) begin
                        grant_o[b] = 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/fbmc_bank.sv
module fbmc_bank
    import fbmc_pkg::*;
#(
    parameter int OFF_W   = 8,
    parameter int DATA_W  = 8,
    parameter int SEQ_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              page_mode_i,
    input  logic              lock_i,
    input  logic              rdprot_i,
    input  logic              grant_i,
    input  logic              done_i,
    output logic              req_erase_o,
    output logic              busy_o,
    output logic              erase_o,
    output logic              start_o,
    output logic              seq_err_o,
    output logic              prot_err_o,
    output logic              pbuf_ack_o
);

    localparam int STG_W = $clog2(SEQ_LEN);

    typedef struct packed {
        logic [STG_W-1:0] stage;
        logic             busy;
        logic             erase;
        logic             start;
        logic             seq_err;
        logic             prot_err;
        logic             pbuf_ack;
    } bank_st_t;

    bank_st_t  st_d, st_q;
    seq_kind_e kind;
    opc_e      opc;

    fbmc_seq_dec #(
        .OFF_W   (OFF_W),
        .DATA_W  (DATA_W),
        .SEQ_LEN (SEQ_LEN),
        .STG_W   (STG_W)
    ) dec_i (
        .stage_i     (st_q.stage),
        .off_i       (off_i),
        .data_i      (data_i),
        .page_mode_i (page_mode_i),
        .kind_o      (kind),
        .opc_o       (opc)
    );

    assign req_erase_o = (opc == OPC_ERASE);

    always_comb begin
        st_d          = st_q;
        st_d.start    = 1'b0;
        st_d.seq_err  = 1'b0;
        st_d.prot_err = 1'b0;
        st_d.pbuf_ack = 1'b0;

        if (st_q.busy && done_i) begin
            st_d.busy = 1'b0;
        end

        if (hit_i) begin
            unique case (kind)
                KIND_PAGE: begin
                    if (st_q.busy)    st_d.seq_err  = 1'b1;
                    else if (rdprot_i) st_d.prot_err = 1'b1;
                    else              st_d.pbuf_ack = 1'b1;
                end
                KIND_STEP: begin
                    st_d.stage = st_q.stage + STG_W'(1);
                end
                KIND_LAST: begin
                    st_d.stage = '0;
                    if (opc == OPC_PROG || opc == OPC_ERASE) begin
                        if (lock_i || (opc == OPC_PROG && rdprot_i)) begin
                            st_d.prot_err = 1'b1;
                        end else if (st_q.busy || !grant_i) begin
                            st_d.seq_err = 1'b1;
                        end else begin
                            st_d.busy  = 1'b1;
                            st_d.erase = (opc == OPC_ERASE);
                            st_d.start = 1'b1;
                        end
                    end
                end
                default: begin
                    st_d.stage   = '0;
                    st_d.seq_err = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o     = st_q.busy;
    assign erase_o    = st_q.erase;
    assign start_o    = st_q.start;
    assign seq_err_o  = st_q.seq_err;
    assign prot_err_o = st_q.prot_err;
    assign pbuf_ack_o = st_q.pbuf_ack;

endmodule

// File: rtl/fbmc_top.sv
module fbmc_top
    import fbmc_pkg::*;
#(
    parameter int NUM_BANKS   = 3,
    parameter int PROG_BANK   = 0,
    parameter int OFF_W       = 8,
    parameter int DATA_W      = 8,
    parameter int SEQ_LEN     = 3,
    parameter int RAMP_CYCLES = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en_i,
    input  logic [$clog2(NUM_BANKS+1)+OFF_W-1:0]   wr_addr_i,
    input  logic [DATA_W-1:0]                      wr_data_i,
    input  logic                                   page_mode_i,
    input  logic [NUM_BANKS-1:0]                   lock_i,
    input  logic [NUM_BANKS-1:0]                   rdprot_i,
    input  logic [NUM_BANKS-1:0]                   arr_done_i,
    output logic                                   ready_o,
    output logic [NUM_BANKS-1:0]                   cmd_mode_o,
    output logic [NUM_BANKS-1:0]                   arr_start_o,
    output logic [NUM_BANKS-1:0]                   arr_erase_o,
    output logic [NUM_BANKS-1:0]                   seq_err_o,
    output logic [NUM_BANKS-1:0]                   prot_err_o,
    output logic                                   pbuf_ack_o,
    output logic                                   reg_ack_o
);

    localparam int SEL_W   = $clog2(NUM_BANKS + 1);
    localparam int RAMP_W  = $clog2(RAMP_CYCLES + 1);
    localparam int REG_SEL = NUM_BANKS;

    typedef struct packed {
        logic [RAMP_W-1:0] ramp_cnt;
        logic              reg_ack;
    } top_st_t;

    top_st_t top_d, top_q;

    logic [SEL_W-1:0]     sel;
    logic [OFF_W-1:0]     off;
    logic                 ready;
    logic [NUM_BANKS-1:0] hit;
    logic [NUM_BANKS-1:0] busy;
    logic [NUM_BANKS-1:0] erase;
    logic [NUM_BANKS-1:0] req_erase;
    logic [NUM_BANKS-1:0] grant;
    logic [NUM_BANKS-1:0] pbuf_vec;

    assign sel   = wr_addr_i[SEL_W+OFF_W-1 -: SEL_W];
    assign off   = wr_addr_i[OFF_W-1:0];
    assign ready = (top_q.ramp_cnt == RAMP_W'(RAMP_CYCLES));

    always_comb begin
        top_d = top_q;
        if (!ready) begin
            top_d.ramp_cnt = top_q.ramp_cnt + RAMP_W'(1);
        end
        top_d.reg_ack = wr_en_i && (sel == SEL_W'(REG_SEL));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    fbmc_arb #(
        .NUM_BANKS (NUM_BANKS),
        .PROG_BANK (PROG_BANK)
    ) arb_i (
        .busy_i      (busy),
        .erase_i     (erase),
        .req_erase_i (req_erase),
        .grant_o     (grant)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign hit[b] = wr_en_i && ready && (sel == SEL_W'(b));

        fbmc_bank #(
            .OFF_W   (OFF_W),
            .DATA_W  (DATA_W),
            .SEQ_LEN (SEQ_LEN)
        ) bank_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .hit_i       (hit[b]),
            .off_i       (off),
            .data_i      (wr_data_i),
            .page_mode_i (page_mode_i),
            .lock_i      (lock_i[b]),
            .rdprot_i    (rdprot_i[b]),
            .grant_i     (grant[b]),
            .done_i      (arr_done_i[b]),
            .req_erase_o (req_erase[b]),
            .busy_o      (busy[b]),
            .erase_o     (erase[b]),
            .start_o     (arr_start_o[b]),
            .seq_err_o   (seq_err_o[b]),
            .prot_err_o  (prot_err_o[b]),
            .pbuf_ack_o  (pbuf_vec[b])
        );
    end

    assign ready_o     = ready;
    assign cmd_mode_o  = busy;
    assign arr_erase_o = erase;
    assign pbuf_ack_o  = |pbuf_vec;
    assign reg_ack_o   = top_q.reg_ack;

endmodule

// File: rtl/fbmc_checker.sv
module fbmc_checker #(
    parameter int NUM_BANKS = 3,
    parameter int PROG_BANK = 0,
    parameter int OFF_W     = 8
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 wr_en_i,
    input logic [$clog2(NUM_BANKS+1)+OFF_W-1:0] wr_addr_i,
    input logic [NUM_BANKS-1:0]                 arr_done_i,
    input logic                                 ready_o,
    input logic [NUM_BANKS-1:0]                 cmd_mode_o,
    input logic [NUM_BANKS-1:0]                 arr_start_o,
    input logic [NUM_BANKS-1:0]                 arr_erase_o,
    input logic [NUM_BANKS-1:0]                 seq_err_o,
    input logic                                 reg_ack_o
);

    localparam int SEL_W = $clog2(NUM_BANKS + 1);

    logic reg_wr;
    assign reg_wr = wr_en_i && (wr_addr_i[SEL_W+OFF_W-1 -: SEL_W] == SEL_W'(NUM_BANKS));

    assert_ramp_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |=> (arr_start_o == '0) && (seq_err_o == '0) && (cmd_mode_o == '0));

    assert_reg_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> reg_ack_o);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        assert_start_enters_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
            arr_start_o[b] |-> cmd_mode_o[b] && !$past(cmd_mode_o[b]));

        assert_done_returns_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_mode_o[b] && arr_done_i[b]) |=> !cmd_mode_o[b]);

        assert_fault_keeps_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (seq_err_o[b] && !$past(arr_done_i[b])) |-> (cmd_mode_o[b] == $past(cmd_mode_o[b])));

        for (genvar c = b + 1; c < NUM_BANKS; c++) begin : g_pair
            assert_pair_allowed_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd_mode_o[b] && cmd_mode_o[c]) |->
                    ((b != PROG_BANK) && (c != PROG_BANK) && (arr_erase_o[b] != arr_erase_o[c])));
        end
    end

endmodule

bind fbmc_top fbmc_checker #(
    .NUM_BANKS (NUM_BANKS),
    .PROG_BANK (PROG_BANK),
    .OFF_W     (OFF_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .arr_done_i  (arr_done_i),
    .ready_o     (ready_o),
    .cmd_mode_o  (cmd_mode_o),
    .arr_start_o (arr_start_o),
    .arr_erase_o (arr_erase_o),
    .seq_err_o   (seq_err_o),
    .reg_ack_o   (reg_ack_o)
);

// File: tb/fbmc_top_tb_top.sv
module fbmc_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 3;
    localparam int RAMP       = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [9:0] wr_addr;
    logic [7:0] wr_data;
    logic       page_mode;
    logic [2:0] lock, rdprot, arr_done;
    logic       ready;
    logic [2:0] cmd_mode, arr_start, arr_erase, seq_err, prot_err;
    logic       pbuf_ack, reg_ack;

    fbmc_top #(
        .NUM_BANKS   (NB),
        .PROG_BANK   (0),
        .OFF_W       (8),
        .DATA_W      (8),
        .SEQ_LEN     (3),
        .RAMP_CYCLES (RAMP)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .page_mode_i (page_mode),
        .lock_i      (lock),
        .rdprot_i    (rdprot),
        .arr_done_i  (arr_done),
        .ready_o     (ready),
        .cmd_mode_o  (cmd_mode),
        .arr_start_o (arr_start),
        .arr_erase_o (arr_erase),
        .seq_err_o   (seq_err),
        .prot_err_o  (prot_err),
        .pbuf_ack_o  (pbuf_ack),
        .reg_ack_o   (reg_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit m_busy  [3];
    bit m_erase [3];
    int m_stage [3];

    task automatic chk_eq(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [2:0] busy_vec();
        return {m_busy[2], m_busy[1], m_busy[0]};
    endfunction

    function automatic bit grant_ok(int b, bit er);
        for (int c = 0; c < NB; c++) begin
            if (c != b && m_busy[c]) begin
                if (b == 0 || c == 0) return 1'b0;
                if (m_erase[c] == er) return 1'b0;
            end
        end
        return 1'b1;
    endfunction

    task automatic bus_write(logic [9:0] a, logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wr_chk(int b, logic [7:0] off, logic [7:0] d);
        logic [2:0] e_start = '0, e_serr = '0, e_perr = '0;
        bit e_pack = 0, e_rack = 0;
        if (b == 3) begin
            e_rack = 1;
        end else if (page_mode && off[7:6] == 2'b11) begin
            if (m_busy[b])       e_serr[b] = 1'b1;
            else if (rdprot[b])  e_perr[b] = 1'b1;
            else                 e_pack    = 1;
        end else if (m_stage[b] == 2) begin
            m_stage[b] = 0;
            if (off == 8'h55 && (d == 8'hA0 || d == 8'h80)) begin
                bit er = (d == 8'h80);
                if (lock[b] || (!er && rdprot[b])) e_perr[b] = 1'b1;
                else if (m_busy[b] || !grant_ok(b, er)) e_serr[b] = 1'b1;
                else begin
                    e_start[b] = 1'b1;
                    m_busy[b]  = 1;
                    m_erase[b] = er;
                end
            end else if (!(off == 8'h55 && d == 8'hF0)) begin
                e_serr[b] = 1'b1;
            end
        end else if (m_stage[b] == 0 && off == 8'h55 && d == 8'hAA) begin
            m_stage[b] = 1;
        end else if (m_stage[b] == 1 && off == 8'hAA && d == 8'h55) begin
            m_stage[b] = 2;
        end else begin
            m_stage[b] = 0;
            e_serr[b]  = 1'b1;
        end
        bus_write({2'(b), off}, d);
        chk_eq("R3", "arr_start", int'(arr_start), int'(e_start));
        chk_eq("R6", "seq_err", int'(seq_err), int'(e_serr));
        chk_eq("R7", "prot_err", int'(prot_err), int'(e_perr));
        chk_eq("R10", "pbuf_ack", int'(pbuf_ack), int'(e_pack));
        chk_eq("R9", "reg_ack", int'(reg_ack), int'(e_rack));
        chk_eq("R4", "cmd_mode", int'(cmd_mode), int'(busy_vec()));
        for (int k = 0; k < NB; k++) begin
            if (m_busy[k]) chk_eq("R8", "arr_erase", int'(arr_erase[k]), int'(m_erase[k]));
        end
    endtask

    task automatic seq(int b, logic [7:0] opc);
        wr_chk(b, 8'h55, 8'hAA);
        wr_chk(b, 8'hAA, 8'h55);
        wr_chk(b, 8'h55, opc);
    endtask

    task automatic do_done(int b);
        arr_done[b] = 1'b1;
        @(negedge clk);
        arr_done = '0;
        m_busy[b] = 0;
        chk_eq("R4", "cmd_mode after done", int'(cmd_mode), int'(busy_vec()));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int waited;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        page_mode = 1'b0; lock = '0; rdprot = '0; arr_done = '0;
        for (int k = 0; k < NB; k++) begin m_busy[k] = 0; m_erase[k] = 0; m_stage[k] = 0; end
        repeat (3) @(negedge clk);
        chk_eq("R1", "cmd_mode in reset", int'(cmd_mode), 0);
        chk_eq("R1", "ready in reset", int'(ready), 0);
        rst_n = 1'b1;

        // R1: a complete program sequence during ramp-up is ignored
        bus_write({2'd1, 8'h55}, 8'hAA);
        bus_write({2'd1, 8'hAA}, 8'h55);
        bus_write({2'd1, 8'h55}, 8'hA0);
        chk_eq("R1", "start during ramp", int'(arr_start), 0);
        chk_eq("R1", "seq_err during ramp", int'(seq_err), 0);
        chk_eq("R1", "cmd_mode during ramp", int'(cmd_mode), 0);
        chk_eq("R1", "ready during ramp", int'(ready), 0);
        // R9: register space answered during ramp
        bus_write({2'd3, 8'h10}, 8'h01);
        chk_eq("R9", "reg_ack during ramp", int'(reg_ack), 1);
        waited = 4;
        while (!ready && waited < RAMP + 4) begin
            @(negedge clk);
            waited++;
        end
        chk_eq("R1", "ready after ramp", int'(ready), 1);
        chk_eq("R1", "ramp length", waited, RAMP);

        // R2: key writes keep read mode
        wr_chk(1, 8'h55, 8'hAA);
        chk_eq("R2", "read mode after key 1", int'(cmd_mode[1]), 0);
        wr_chk(1, 8'hAA, 8'h55);
        chk_eq("R2", "read mode after key 2", int'(cmd_mode[1]), 0);
        wr_chk(1, 8'h55, 8'hA0);
        chk_eq("R3", "program start", int'(arr_start[1]), 1);

        // R5: reset-to-read while busy has no effect
        seq(1, 8'hF0);
        chk_eq("R5", "busy kept after reset-to-read", int'(cmd_mode[1]), 1);

        // R8: erase the other data bank while programming
        seq(2, 8'h80);
        chk_eq("R8", "data banks concurrent", int'(cmd_mode), 3'b110);
        seq(0, 8'hA0);
        chk_eq("R8", "program bank refused", int'(seq_err[0]), 1);
        chk_eq("R8", "busy banks undisturbed", int'(cmd_mode), 3'b110);
        do_done(1);
        do_done(2);
        chk_eq("R4", "all read", int'(cmd_mode), 0);

        // R8: same operation on both data banks refused
        seq(1, 8'hA0);
        seq(2, 8'hA0);
        chk_eq("R8", "same op refused", int'(seq_err[2]), 1);
        seq(0, 8'h80);
        do_done(1);

        // R6: wrong order, then a clean sequence still works
        wr_chk(0, 8'h55, 8'hAA);
        wr_chk(0, 8'h55, 8'hAA);
        chk_eq("R6", "order fault", int'(seq_err[0]), 1);
        seq(0, 8'h80);
        chk_eq("R6", "restart after fault", int'(cmd_mode[0]), 1);
        do_done(0);
        wr_chk(0, 8'h55, 8'hAA);
        wr_chk(0, 8'hAA, 8'h55);
        wr_chk(0, 8'h55, 8'h77);
        chk_eq("R6", "bad opcode", int'(seq_err[0]), 1);

        // R7: lock and read protection
        lock = 3'b001;
        seq(0, 8'h80);
        chk_eq("R7", "locked erase", int'(prot_err[0]), 1);
        lock = '0;
        rdprot = 3'b010;
        seq(1, 8'hA0);
        chk_eq("R7", "protected program", int'(prot_err[1]), 1);
        seq(1, 8'h80);
        chk_eq("R7", "protected erase allowed", int'(cmd_mode[1]), 1);
        do_done(1);
        rdprot = '0;

        // R10: page buffer write inside a sequence
        page_mode = 1'b1;
        wr_chk(2, 8'h55, 8'hAA);
        wr_chk(2, 8'hC4, 8'h3C);
        chk_eq("R10", "page write acked", int'(pbuf_ack), 1);
        wr_chk(2, 8'hAA, 8'h55);
        wr_chk(2, 8'h55, 8'hA0);
        chk_eq("R10", "sequence survived page write", int'(cmd_mode[2]), 1);
        wr_chk(2, 8'hC8, 8'h11);
        do_done(2);
        page_mode = 1'b0;
        wr_chk(2, 8'hC4, 8'h3C);
        chk_eq("R10", "page write without page mode", int'(seq_err[2]), 1);

        // R9 while busy, R5 in read mode
        seq(0, 8'h80);
        wr_chk(3, 8'h20, 8'h02);
        do_done(0);
        seq(1, 8'hF0);
        chk_eq("R5", "reset-to-read in read mode", int'(cmd_mode[1]), 0);

        // Random phase
        void'($urandom(32'd4242));
        for (int it = 0; it < 500; it++) begin
            int act = $urandom % 10;
            lock      = (($urandom % 8) == 0) ? 3'($urandom) : 3'b000;
            rdprot    = (($urandom % 8) == 0) ? 3'($urandom) : 3'b000;
            page_mode = 1'($urandom);
            if (act < 5) begin
                int b   = $urandom % 3;
                int opk = $urandom % 3;
                int bad = (($urandom % 5) == 0) ? int'($urandom % 3) : -1;
                logic [7:0] offs [3] = '{8'h55, 8'hAA, 8'h55};
                logic [7:0] dats [3];
                dats[0] = 8'hAA;
                dats[1] = 8'h55;
                dats[2] = (opk == 0) ? 8'hA0 : ((opk == 1) ? 8'h80 : 8'hF0);
                for (int k = 0; k < 3; k++) begin
                    wr_chk(b, offs[k], (k == bad) ? (dats[k] ^ 8'h01) : dats[k]);
                end
            end else if (act < 7) begin
                do_done($urandom % 3);
            end else if (act == 7) begin
                wr_chk(3, 8'($urandom), 8'($urandom));
            end else if (act == 8) begin
                wr_chk($urandom % 3, {2'b11, 6'($urandom)}, 8'($urandom));
            end else begin
                wr_chk($urandom % 3, 8'($urandom), 8'($urandom));
            end
        end
        lock = '0;
        rdprot = '0;
        finish_run();
    end

endmodule